// File: doc/BRIEF.md
# Half-Duplex Modem Direction Switch

This block manages the turnaround between receive and transmit in a half-duplex serial modem datapath. A host selects the direction with a single level input. The block then sequences the bit-rate data clock it supplies to the host, the direction of the shared data pin, and the gating of the transmit bit stream toward the modulator. One free-running divider sets the bit period, and every timing decision lands on its boundaries.

In receive, the data clock free-runs and already-sliced receive bits reach the data pin after a fixed pipeline delay. When transmit is selected, the clock is parked low for two to three bit periods and the pin driver is released. At the first rising clock edge, the block starts sampling host bits and ungates the transmit output. The output lags by a fixed filter latency, and after the last bit it keeps that bit's level. When receive is selected again, the transmit output falls back to idle and the pin driver takes over immediately.

Top module: `half_duplex_turnaround`

## Requirements
- R1: The direction select passes through a two-flop synchroniser. Two rising clock edges after the select goes high, `pin_oe` drops to 0 and `dclk` is 0 in that same cycle, even if `dclk` was high.
- R2: On entering transmit, `dclk` stays low for a whole number of cycles in the range 2·CLKS_PER_BIT+1 to 3·CLKS_PER_BIT. Counting from the first cycle with the synchronised select high and the divider phase c (0 to CLKS_PER_BIT−1), the low time is 3·CLKS_PER_BIT − c cycles. The next divider bit boundary after two full bit periods ends the low time.
- R3: In transmit, `pin_in` is sampled on the clock edge that closes the first system-clock cycle of each high `dclk` phase. The first such sample is taken at the first rising transmit clock.
- R4: `tx_idle` is 1 in receive and while `dclk` is held low. It falls to 0 in the cycle where the first transmit `dclk` rise appears.
- R5: With NARROW_FILTER=0, the bit sampled at rising edge k is visible on `tx_bit` at mid-bit of period k+2. With NARROW_FILTER=1, it is visible from after mid-bit of period k+2 until mid-bit of period k+3, which is a 2.5-bit lag.
- R6: When the host stops changing `pin_in`, `tx_bit` settles to the last bit sent and keeps it for as long as transmit lasts.
- R7: In the cycle where the synchronised select returns to receive, `pin_oe` is 1, `tx_idle` is 1 and `pin_out` shows receive-pipeline data.
- R8: In receive and in transmit after the hold, `dclk` has a period of CLKS_PER_BIT cycles and is high for CLKS_PER_BIT/2 of them, starting at the divider bit boundary.
- R9: A bit on `rx_bit` sampled at the start of bit period k appears on `pin_out` at mid-bit of period k+3.
- R10: If the direction changes back during the hold, the hold restarts from its first step on the next entry to transmit. The hold length then follows R2 again.
- R11: After reset, `pin_oe`=1, `tx_idle`=1, `tx_bit`=0 and `pin_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_sel | input | 1 | Direction select, 1 = transmit, asynchronous |
| pin_in | input | 1 | Data pin input from the host (transmit bits) |
| rx_bit | input | 1 | Sliced receive bit stream |
| pin_out | output | 1 | Data pin output value (delayed receive bits) |
| pin_oe | output | 1 | Data pin driver enable, 1 in receive |
| dclk | output | 1 | Bit-rate data clock to the host |
| tx_bit | output | 1 | Filtered transmit bit toward the modulator |
| tx_idle | output | 1 | 1 while the transmit output sits at bias level |

## Verification
The bench enters transmit at every divider phase and checks the exact hold length. A design that counted two boundaries instead of three would release the clock early, and one that ignored the divider phase would give a constant hold. It walks bit patterns through both directions and both filter settings, so an off-by-one-bit pipeline or a sample on the wrong edge shows up as shifted bits. It aborts a hold halfway and re-enters, which catches a hold counter that is not cleared. It also checks that idle and pin direction flip in the very cycle the synchronised select falls, which a design registering those outputs would miss by a cycle.

// File: rtl/half_duplex_turnaround.sv
module half_duplex_turnaround #(
  parameter int CLKS_PER_BIT  = 8,
  parameter bit NARROW_FILTER = 1'b0,
  parameter int RX_LAT_BITS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_sel,
  input  logic pin_in,
  input  logic rx_bit,
  output logic pin_out,
  output logic pin_oe,
  output logic dclk,
  output logic tx_bit,
  output logic tx_idle
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int TXD  = NARROW_FILTER ? 3 : 2;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF);

  logic [CW-1:0]        cnt;
  logic                 sel_s1, sel_s2, run_q;
  logic [1:0]           hold_bits;
  logic [TXD-1:0]       tx_sh;
  logic                 tx_q;
  logic [RX_LAT_BITS:0] rx_sh;

  wire tick    = (cnt == LAST);
  wire bit_beg = (cnt == '0);
  wire tx_load = NARROW_FILTER ? (cnt == MID) : bit_beg;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_s1 <= 1'b0;
      sel_s2 <= 1'b0;
    end else begin
      sel_s1 <= tx_sel;
      sel_s2 <= sel_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sel_s2) begin
      run_q     <= 1'b0;
      hold_bits <= '0;
    end else if (!run_q && tick) begin
      hold_bits <= hold_bits + 1'b1;
      if (hold_bits == 2'd2) run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_q) begin
      tx_sh <= '0;
      tx_q  <= 1'b0;
    end else begin
      if (bit_beg) tx_sh <= {tx_sh[TXD-2:0], pin_in};
      if (tx_load) tx_q  <= tx_sh[TXD-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_sh <= '0;
    else if (bit_beg) rx_sh <= {rx_sh[RX_LAT_BITS-1:0], rx_bit};
  end

  assign pin_out = rx_sh[RX_LAT_BITS];
  assign pin_oe  = !sel_s2;
  assign dclk    = (!sel_s2 || run_q) && (cnt < MID);
  assign tx_bit  = tx_q;
  assign tx_idle = !(sel_s2 && run_q);

  localparam int HW = $clog2(3 * CLKS_PER_BIT + 2) + 1;
  logic [HW-1:0] hold_cyc;
  always_ff @(posedge clk) begin
    if (!rst_n || !sel_s2)   hold_cyc <= '0;
    else if (!run_q)         hold_cyc <= hold_cyc + 1'b1;
  end

  assert_clock_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_s2) |-> (!dclk && !pin_oe));

  assert_hold_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (hold_cyc >= HW'(2 * CLKS_PER_BIT + 1) && hold_cyc <= HW'(3 * CLKS_PER_BIT)));

  assert_ungate_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_idle) |-> (dclk && bit_beg));

  assert_back_to_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_s2) |-> (tx_idle && pin_oe));

  assert_run_only_in_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (sel_s2 && $past(sel_s2)));
endmodule

// File: tb/test_half_duplex_turnaround.sv
module test_half_duplex_turnaround;
  localparam int N = 8;
  localparam int L = 12;
  localparam logic [L-1:0] PATS [4] = '{12'b101100111000, 12'b010101010101,
                                       12'b111111000000, 12'b100000000001};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tx_sel, pin_in, rx_bit;
  logic pin_out, pin_oe, dclk, tx_bit, tx_idle;
  logic n_pin_out, n_pin_oe, n_dclk, n_tx_bit, n_tx_idle;
  int checks = 0, fails = 0;

  half_duplex_turnaround #(.CLKS_PER_BIT(N), .NARROW_FILTER(1'b0)) i_half_duplex_turnaround (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .pin_in(pin_in), .rx_bit(rx_bit),
    .pin_out(pin_out), .pin_oe(pin_oe), .dclk(dclk), .tx_bit(tx_bit), .tx_idle(tx_idle));

  half_duplex_turnaround #(.CLKS_PER_BIT(N), .NARROW_FILTER(1'b1)) i_half_duplex_turnaround_narrow (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .pin_in(pin_in), .rx_bit(rx_bit),
    .pin_out(n_pin_out), .pin_oe(n_pin_oe), .dclk(n_dclk), .tx_bit(n_tx_bit), .tx_idle(n_tx_idle));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure_hold(output int n, output logic idle_ok);
    int w = 0;
    @(negedge clk);
    while (pin_oe && w < 20) begin w++; @(negedge clk); end
    chk("R1 dclk low at entry", dclk, 1'b0);
    n = 0;
    idle_ok = 1'b1;
    while (!dclk && n < 10 * N) begin
      if (!tx_idle) idle_ok = 1'b0;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_period(input string req);
    int hi = 0;
    @(posedge dclk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      hi += int'(dclk);
      @(negedge clk);
    end
    chk_int({req, " high cycles"}, hi, N / 2);
    chk({req, " next rise on boundary"}, dclk, 1'b1);
  endtask

  task automatic run_rx(input logic [L-1:0] pat);
    @(negedge dclk);
    @(negedge clk);
    rx_bit = pat[0];
    for (int p = 0; p < L + 3; p++) begin
      @(negedge dclk);
      @(negedge clk);
      if (p >= 3) chk("R9 rx latency", pin_out, pat[p-3]);
      rx_bit = (p + 1 < L) ? pat[p+1] : 1'b1;
    end
  endtask

  task automatic run_tx(input logic [L-1:0] pat);
    int n;
    logic idle_ok;
    pin_in = pat[0];
    tx_sel = 1'b1;
    measure_hold(n, idle_ok);
    chk("R4 idle during hold", idle_ok, 1'b1);
    chk("R2 hold in window", (n >= 2 * N + 1 && n <= 3 * N), 1'b1);
    chk("R4 ungated at first rise", tx_idle, 1'b0);
    for (int p = 0; p < L + 5; p++) begin
      @(negedge dclk);
      @(negedge clk);
      if (p >= 2) chk((p - 2 < L) ? "R3 R5 tx lag 2 bits" : "R6 last bit held",
                      tx_bit, pat[(p - 2 < L) ? p - 2 : L - 1]);
      if (p >= 3) chk((p - 3 < L) ? "R5 narrow tx lag" : "R6 narrow last bit held",
                      n_tx_bit, pat[(p - 3 < L) ? p - 3 : L - 1]);
      pin_in = (p + 1 < L) ? pat[p+1] : pat[L-1];
    end
    check_period("R8 tx clock");
    tx_sel = 1'b0;
    @(negedge clk);
    while (!pin_oe) @(negedge clk);
    chk("R7 idle on return", tx_idle, 1'b1);
    chk("R7 rx data on pin", pin_out, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic idle_ok;
    rst_n = 1'b0; tx_sel = 1'b0; pin_in = 1'b0; rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset pin_oe", pin_oe, 1'b1);
    chk("R11 reset tx_idle", tx_idle, 1'b1);
    chk("R11 reset tx_bit", tx_bit, 1'b0);
    chk("R11 reset pin_out", pin_out, 1'b0);
    rst_n = 1'b1;
    check_period("R8 rx clock");

    for (int v = 0; v < 4; v++) begin
      run_rx(PATS[v]);
      rx_bit = 1'b1;
      repeat (5 * N) @(negedge clk);
      run_tx(PATS[v]);
      check_period("R8 clock after return");
    end

    for (int off = 1; off <= N; off++) begin
      tx_sel = 1'b0;
      repeat (3 * N) @(negedge clk);
      @(posedge dclk);
      repeat (off) @(negedge clk);
      tx_sel = 1'b1;
      measure_hold(n, idle_ok);
      chk_int("R2 exact hold by phase", n, 3 * N - ((off + 1) % N));
    end

    tx_sel = 1'b0;
    repeat (3 * N) @(negedge clk);
    tx_sel = 1'b1;
    @(negedge clk);
    chk("R1 sync first stage", pin_oe, 1'b1);
    @(negedge clk);
    chk("R1 sync second stage", pin_oe, 1'b0);
    repeat (N + 3) @(negedge clk);
    chk("R10 still parked", dclk, 1'b0);
    tx_sel = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 back in rx", pin_oe, 1'b1);
    tx_sel = 1'b1;
    measure_hold(n, idle_ok);
    chk("R10 restarted hold in window", (n >= 2 * N + 1 && n <= 3 * N), 1'b1);
    chk("R10 idle during restarted hold", idle_ok, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule